// File: doc/BRIEF.md
# Split-Transaction Memory Responder

This block is the memory side of a shared processor-memory bus that runs split transactions. A requester presents an operation (read or write), a word address, write data and a transaction tag for a single cycle. The responder captures it and leaves the bus free. The access itself runs inside the block with a fixed latency. Reads and writes each have their own latency. Because the bus is not held during that latency, new address phases can overlap the fetches that are already in flight.

Once an access has finished its latency, the responder raises a bus request. It keeps the request up until the arbiter grants it. It then drives the response for one cycle: the original tag, the data and a flag that marks a write acknowledge. Pending accesses sit in an age-ordered queue of parameter depth. In the default mode the oldest finished access is returned first, so a short write may overtake a longer read. With `IN_ORDER` set, only the oldest pending access may return.

The memory array is touched when a request is accepted. Data therefore always follows acceptance order, even when responses come back out of order.

Top module: `split_mem_responder`

## Requirements
- R1: After reset, `bus_req_o` and `rsp_valid_o` are low, `req_accept_o` is high, and no access is pending.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_accept_o` are both high. `req_accept_o` is low while `DEPTH` (default 4) accesses are pending. A request presented while accept is low is dropped and never produces a response.
- R3: A read returns the data of the latest write to the same address that was accepted before it. A word that has never been written reads as zero.
- R4: A read becomes eligible for return `RD_LAT` (default 4) rising edges after the edge that accepted it. A write becomes eligible after `WR_LAT` (default 1) edges. `bus_req_o` rises at that point if the return path is idle and the oldest-ready rule selects this access.
- R5: Once raised, `bus_req_o` stays high on every cycle until it is sampled high together with `bus_gnt_i`.
- R6: The cycle after a grant edge, `rsp_valid_o` is high for exactly one cycle and `bus_req_o` is low during that cycle.
- R7: A response carries the tag of its request on `rsp_tag_o`. For a write, `rsp_write_o` is 1 and `rsp_data_o` echoes the written data. For a read, `rsp_write_o` is 0.
- R8: With `IN_ORDER`=0, the oldest eligible access is returned first. A write accepted after a read can therefore be returned before that read.
- R9: With `IN_ORDER`=1, responses leave in acceptance order, even when a younger access became eligible earlier.
- R10: New requests are accepted on consecutive cycles while earlier accesses are still counting their latency.
- R11: `bus_gnt_i` has no effect while `bus_req_o` is low: no response is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Address phase present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_tag_i | input | TAG_W | Transaction tag |
| req_accept_o | output | 1 | Queue has room for a request |
| bus_req_o | output | 1 | Request for bus ownership to return a response |
| bus_gnt_i | input | 1 | Bus ownership granted |
| rsp_valid_o | output | 1 | Response phase on the bus |
| rsp_tag_o | output | TAG_W | Tag of the returned access |
| rsp_data_o | output | DATA_W | Read data or echoed write data |
| rsp_write_o | output | 1 | Response is a write acknowledge |

## Verification
The assertions assume an arbiter that treats `bus_gnt_i` as meaningful only while `bus_req_o` is high. They also assume a requester that watches `req_accept_o` instead of forcing a request into a full queue. The stimulus drives inputs only between clock edges and pulses grant for one cycle at a time. Grant is raised only after `bus_req_o` has been seen high, except in the single test that checks a stray grant is ignored. The full-queue case deliberately holds `req_valid_i` high while accept is low. It then checks at the response port that the rejected request never comes back.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic {
    RS_IDLE  = 1'b0,
    RS_DRIVE = 1'b1
  } rsp_state_e;
endpackage

// File: rtl/smr_store.sv
module smr_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/smr_queue.sv
// Age-ordered pending queue: slot 0 is oldest, a pop from any slot collapses the rest down.
module smr_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int LAT_W  = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          push_write_i,
  input  logic [TAG_W-1:0]              push_tag_i,
  input  logic [DATA_W-1:0]             push_data_i,
  input  logic [LAT_W-1:0]              push_lat_i,
  input  logic                          pop_i,
  input  logic [IDX_W-1:0]              pop_idx_i,
  output logic                          full_o,
  output logic [DEPTH-1:0]              ready_o,
  output logic [DEPTH-1:0]              slot_write_o,
  output logic [DEPTH-1:0][TAG_W-1:0]   slot_tag_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  slot_data_o
);
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  count_kept;
  logic              wr_q   [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [LAT_W-1:0]  lat_q  [DEPTH];

  assign count_kept = count_q - CNT_W'(pop_i);
  assign full_o     = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_kept + CNT_W'(push_i);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              shift;
    logic              src_wr;
    logic [TAG_W-1:0]  src_tag;
    logic [DATA_W-1:0] src_data;
    logic [LAT_W-1:0]  src_lat;

    assign shift = pop_i && ({1'b0, IDX_W'(i)} >= {1'b0, pop_idx_i});

    if (i < DEPTH - 1) begin : g_mid
      assign src_wr   = shift ? wr_q[i+1]   : wr_q[i];
      assign src_tag  = shift ? tag_q[i+1]  : tag_q[i];
      assign src_data = shift ? data_q[i+1] : data_q[i];
      assign src_lat  = shift ? lat_q[i+1]  : lat_q[i];
    end else begin : g_top
      assign src_wr   = wr_q[i];
      assign src_tag  = tag_q[i];
      assign src_data = data_q[i];
      assign src_lat  = lat_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q[i]   <= 1'b0;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        lat_q[i]  <= '0;
      end else if (CNT_W'(i) < count_kept) begin
        wr_q[i]   <= src_wr;
        tag_q[i]  <= src_tag;
        data_q[i] <= src_data;
        lat_q[i]  <= (src_lat != '0) ? src_lat - LAT_W'(1) : '0;
      end else if (push_i && (CNT_W'(i) == count_kept)) begin
        wr_q[i]   <= push_write_i;
        tag_q[i]  <= push_tag_i;
        data_q[i] <= push_data_i;
        lat_q[i]  <= push_lat_i;
      end
    end

    assign ready_o[i]      = (CNT_W'(i) < count_q) && (lat_q[i] == '0);
    assign slot_write_o[i] = wr_q[i];
    assign slot_tag_o[i]   = tag_q[i];
    assign slot_data_o[i]  = data_q[i];
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  assert_pop_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> ready_o[pop_idx_i]);
endmodule

// File: rtl/smr_pick.sv
module smr_pick #(
  parameter int DEPTH    = 4,
  parameter bit IN_ORDER = 1'b0,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] ready_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  if (IN_ORDER) begin : g_head
    assign any_o = ready_i[0];
    assign idx_o = '0;
  end else begin : g_oldest
    always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (ready_i[i]) begin
          any_o = 1'b1;
          idx_o = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/split_mem_responder.sv
module split_mem_responder
  import smr_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  parameter int DEPTH    = 4,
  parameter int RD_LAT   = 4,
  parameter int WR_LAT   = 1,
  parameter bit IN_ORDER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              req_accept_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_write_o
);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic                         push;
  logic                         full;
  logic [DATA_W-1:0]            rd_word;
  logic [DATA_W-1:0]            push_data;
  logic [LAT_W-1:0]             push_lat;
  logic [DEPTH-1:0]             ready;
  logic [DEPTH-1:0]             slot_write;
  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic                         any_ready;
  logic [IDX_W-1:0]             sel_idx;
  logic                         take;
  rsp_state_e                   state_q;
  logic [TAG_W-1:0]             tag_q;
  logic [DATA_W-1:0]            data_q;
  logic                         write_q;

  assign req_accept_o = !full;
  assign push         = req_valid_i && req_accept_o;

  // Array is accessed at accept time so data follows acceptance order.
  smr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (push && req_write_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .rdata_o (rd_word)
  );

  assign push_data = req_write_i ? req_wdata_i : rd_word;
  assign push_lat  = req_write_i ? LAT_W'(WR_LAT) : LAT_W'(RD_LAT);

  smr_queue #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .LAT_W(LAT_W)
  ) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_write_i (req_write_i),
    .push_tag_i   (req_tag_i),
    .push_data_i  (push_data),
    .push_lat_i   (push_lat),
    .pop_i        (take),
    .pop_idx_i    (sel_idx),
    .full_o       (full),
    .ready_o      (ready),
    .slot_write_o (slot_write),
    .slot_tag_o   (slot_tag),
    .slot_data_o  (slot_data)
  );

  smr_pick #(.DEPTH(DEPTH), .IN_ORDER(IN_ORDER)) u_pick (
    .ready_i (ready),
    .any_o   (any_ready),
    .idx_o   (sel_idx)
  );

  assign bus_req_o = (state_q == RS_IDLE) && any_ready;
  assign take      = bus_req_o && bus_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      tag_q   <= '0;
      data_q  <= '0;
      write_q <= 1'b0;
    end else if (state_q == RS_DRIVE) begin
      state_q <= RS_IDLE;
    end else if (take) begin
      state_q <= RS_DRIVE;
      tag_q   <= slot_tag[sel_idx];
      data_q  <= slot_data[sel_idx];
      write_q <= slot_write[sel_idx];
    end
  end

  assign rsp_valid_o = (state_q == RS_DRIVE);
  assign rsp_tag_o   = tag_q;
  assign rsp_data_o  = data_q;
  assign rsp_write_o = write_q;

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);

  assert_grant_drives_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i) |=> rsp_valid_o);

  assert_single_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_no_req_in_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !bus_req_o);

  if (IN_ORDER) begin : g_ord_chk
    assert_head_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take |-> (sel_idx == '0));
  end
endmodule

// File: tb/split_mem_responder_bench.sv
module split_mem_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_L = 4;
  localparam int WR_L = 1;

  typedef struct packed {
    logic        w;
    logic [5:0]  a;
    logic [15:0] d;
    logic [3:0]  t;
    logic [15:0] e;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 6'd3,  16'h1234, 4'd1, 16'h1234},
    '{1'b0, 6'd3,  16'h0000, 4'd2, 16'h1234},
    '{1'b0, 6'd10, 16'h0000, 4'd3, 16'h0000},
    '{1'b1, 6'd10, 16'hBEEF, 4'd4, 16'hBEEF},
    '{1'b0, 6'd10, 16'h0000, 4'd5, 16'hBEEF},
    '{1'b1, 6'd63, 16'hA5A5, 4'd6, 16'hA5A5},
    '{1'b0, 6'd63, 16'h0000, 4'd7, 16'hA5A5},
    '{1'b1, 6'd3,  16'h0F0F, 4'd8, 16'h0F0F},
    '{1'b0, 6'd3,  16'h0000, 4'd0, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_valid2 = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic        gnt = 1'b0, gnt2 = 1'b0;
  logic        accept, accept2, bus_req, bus_req2, rsp_valid, rsp_valid2;
  logic        rsp_write, rsp_write2;
  logic [3:0]  rsp_tag, rsp_tag2;
  logic [15:0] rsp_data, rsp_data2;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_mem_responder u_split_mem_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_tag_i(req_tag), .req_accept_o(accept),
    .bus_req_o(bus_req), .bus_gnt_i(gnt),
    .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data),
    .rsp_write_o(rsp_write)
  );

  split_mem_responder #(.IN_ORDER(1'b1)) u_split_mem_responder_ino (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid2), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_tag_i(req_tag), .req_accept_o(accept2),
    .bus_req_o(bus_req2), .bus_gnt_i(gnt2),
    .rsp_valid_o(rsp_valid2), .rsp_tag_o(rsp_tag2), .rsp_data_o(rsp_data2),
    .rsp_write_o(rsp_write2)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(bit sel, bit w, logic [5:0] a, logic [15:0] d, logic [3:0] t);
    req_write = w; req_addr = a; req_wdata = d; req_tag = t;
    if (sel) begin
      chk("R10 accept2", 32'(accept2), 1);
      req_valid2 = 1'b1;
    end else begin
      chk("R10 accept", 32'(accept), 1);
      req_valid = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_valid2 = 1'b0;
  endtask

  task automatic wait_req(bit sel);
    for (int k = 0; k < 40; k++) begin
      if ((sel ? bus_req2 : bus_req) === 1'b1) return;
      @(negedge clk);
    end
    chk("R4 bus_req timeout", 0, 1);
  endtask

  task automatic grant(bit sel, logic [3:0] t, logic [15:0] d, bit w, string rq);
    if (sel) gnt2 = 1'b1; else gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0; gnt2 = 1'b0;
    chk("R6 rsp_valid high", 32'(sel ? rsp_valid2 : rsp_valid), 1);
    chk("R6 bus_req low while driving", 32'(sel ? bus_req2 : bus_req), 0);
    chk({rq, " tag"}, 32'(sel ? rsp_tag2 : rsp_tag), 32'(t));
    chk({rq, " data"}, 32'(sel ? rsp_data2 : rsp_data), 32'(d));
    chk("R7 kind", 32'(sel ? rsp_write2 : rsp_write), 32'(w));
    @(negedge clk);
    chk("R6 single beat", 32'(sel ? rsp_valid2 : rsp_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 accept", 32'(accept), 1);
    chk("R1 bus_req2", 32'(bus_req2), 0);

    // Vector walk: R3, R4, R7
    for (int v = 0; v < NVEC; v++) begin
      int lat;
      lat = VEC[v].w ? WR_L : RD_L;
      issue(1'b0, VEC[v].w, VEC[v].a, VEC[v].d, VEC[v].t);
      repeat (lat - 1) @(negedge clk);
      chk("R4 not yet eligible", 32'(bus_req), 0);
      @(negedge clk);
      chk("R4 eligible", 32'(bus_req), 1);
      grant(1'b0, VEC[v].t, VEC[v].e, VEC[v].w, "R3 R7 vector");
    end

    // R8 and R10: write overtakes an earlier read
    issue(1'b0, 1'b0, 6'd3, 16'h0, 4'd1);
    issue(1'b0, 1'b1, 6'd20, 16'h5555, 4'd2);
    wait_req(1'b0);
    grant(1'b0, 4'd2, 16'h5555, 1'b1, "R8 write first");
    wait_req(1'b0);
    grant(1'b0, 4'd1, 16'h0F0F, 1'b0, "R8 read second");

    // R8 oldest of two ready reads
    issue(1'b0, 1'b0, 6'd20, 16'h0, 4'd7);
    issue(1'b0, 1'b0, 6'd10, 16'h0, 4'd8);
    repeat (8) @(negedge clk);
    grant(1'b0, 4'd7, 16'h5555, 1'b0, "R8 oldest");
    wait_req(1'b0);
    grant(1'b0, 4'd8, 16'hBEEF, 1'b0, "R8 younger");

    // R9 in-order instance
    issue(1'b1, 1'b0, 6'd7, 16'h0, 4'd3);
    issue(1'b1, 1'b1, 6'd7, 16'h7777, 4'd4);
    repeat (6) @(negedge clk);
    wait_req(1'b1);
    grant(1'b1, 4'd3, 16'h0000, 1'b0, "R9 head first");
    wait_req(1'b1);
    grant(1'b1, 4'd4, 16'h7777, 1'b1, "R9 then write");

    // R2 full queue, dropped request
    for (int k = 0; k < 4; k++) issue(1'b0, 1'b0, 6'd63, 16'h0, 4'(9 + k));
    chk("R2 accept low when full", 32'(accept), 0);
    req_tag = 4'd13; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_req(1'b0);
      grant(1'b0, 4'(9 + k), 16'hA5A5, 1'b0, "R2 drain");
    end
    repeat (8) @(negedge clk);
    chk("R2 dropped request not returned", 32'(bus_req), 0);
    chk("R2 accept restored", 32'(accept), 1);

    // R11 stray grant
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk("R11 no response", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R11 no response later", 32'(rsp_valid), 0);

    // R5 request held without grant
    issue(1'b0, 1'b0, 6'd63, 16'h0, 4'd14);
    wait_req(1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5 bus_req held", 32'(bus_req), 1);
      chk("R5 no response before grant", 32'(rsp_valid), 0);
    end
    grant(1'b0, 4'd14, 16'hA5A5, 1'b0, "R5 late grant");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule